// File: doc/BRIEF.md
# Stereo Zero-Run Detector and Mute Gate

This block sits between the audio sample decoder and the interpolation stage of a stereo converter. It receives one left and one right two's-complement sample word per sample period, each marked by a single-cycle strobe. Each channel keeps its own count of consecutive all-zero samples. When that count reaches the selected run length, the channel's active-low flag drops. A nonzero sample on that channel raises the flag again at once.

The same block gates each channel's sample on its way downstream. The sample passes unchanged unless the channel is muted. When muted, the output word is forced to zero, which is midscale and gives a 50% PWM duty further down the chain. A channel is muted by its zero-run detection, by the control register's mute bit, or while the reset input is low. Sample words are held stable by the upstream logic from one strobe to the next. Output gating and the release of a flag follow the sample inputs combinationally.

Top module: `zmute_det`

## Requirements
- R1: While `rst_ni` is low, both output words are zero and both flags are high. Reset clears both run counters, so after release a channel needs a fresh full run of zero samples before its flag drops.
- R2: A run counter changes only on cycles where `sample_stb_i` is high. Zero samples held without strobes never drop a flag.
- R3: With `period_sel_i` = 0, a channel's flag is still high after 2499 consecutive strobed zero samples and goes low once the 2500th has been strobed.
- R4: With `period_sel_i` = 1, the flag is still high after 12 499 consecutive strobed zero samples and goes low once the 12 500th has been strobed.
- R5: When a nonzero sample word is presented on a detected channel, its flag goes high and the word appears on the output in the same cycle, without waiting for a strobe. The next strobe restarts that channel's count from zero.
- R6: The two channels are detected independently. A zero run on one channel does not change the other channel's flag or output.
- R7: While `mute_i` is high, both output words are zero and both flags are low, whatever the sample values.
- R8: A run counter saturates at the selected length. Further zero samples keep the flag low, and changing `period_sel_i` from 1 to 0 on a saturated channel keeps the flag low.
- R9: When a channel is neither in reset nor muted, its output word equals its input sample word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_stb_i | input | 1 | One-cycle strobe marking a new sample pair |
| period_sel_i | input | 1 | Run length select: 0 = 2500 samples, 1 = 12 500 samples |
| mute_i | input | 1 | Control register mute bit |
| sample_l_i | input | 18 | Left sample, two's complement |
| sample_r_i | input | 18 | Right sample, two's complement |
| sample_l_o | output | 18 | Gated left sample |
| sample_r_o | output | 18 | Gated right sample |
| mute_l_no | output | 1 | Left mute flag, active low |
| mute_r_no | output | 1 | Right mute flag, active low |

## Verification
The zero-run detection is driven with zero runs that stop one sample short of each selectable length and then reach it exactly. This separates an off-by-one terminal count from a correct one. Zeros are held for thousands of cycles without strobes to show that the count follows the strobe and not the clock. One channel runs to detection while the other carries a constant nonzero word, which shows the two channels are independent. A nonzero word presented without a strobe shows that release is immediate, and a period switch on a saturated counter shows the saturation behaviour. A short table of sample words, with the mute bit both set and clear, checks the pass-through and mute gating before any run builds up.

// File: rtl/zmute_pkg.sv
package zmute_pkg;
  typedef enum logic {
    PERIOD_SHORT = 1'b0,
    PERIOD_LONG  = 1'b1
  } period_e;

  localparam int unsigned N_CH = 2;
endpackage

// File: rtl/zmute_run_counter.sv
module zmute_run_counter #(
  parameter int unsigned SAMPLE_W  = 18,
  parameter int unsigned SHORT_RUN = 2500,
  parameter int unsigned LONG_RUN  = 12500
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_stb_i,
  input  zmute_pkg::period_e  period_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                run_done_o
);
  localparam int unsigned CNT_W = $clog2(LONG_RUN + 1);
  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_RUN);
  localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_RUN);

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] limit;
  logic             is_zero;

  assign limit   = (period_i == zmute_pkg::PERIOD_LONG) ? LONG_C : SHORT_C;
  assign is_zero = (sample_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (sample_stb_i) begin
      if (!is_zero)           run_q <= '0;
      else if (run_q < limit) run_q <= run_q + 1'b1;
    end
  end

  // >= so a shrinking period still reports a saturated run
  assign run_done_o = (run_q >= limit);

  AST_RUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_stb_i |=> $stable(run_q)); // R2
  AST_RUN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_stb_i && is_zero && run_q < limit) |=> (run_q == $past(run_q) + 1'b1)); // R3
  AST_RUN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_stb_i && !is_zero) |=> (run_q == '0)); // R5
  AST_RUN_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_stb_i && is_zero && run_q >= limit) |=> $stable(run_q)); // R8
  AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= LONG_C); // R8
endmodule

// File: rtl/zmute_gate.sv
module zmute_gate #(
  parameter int unsigned SAMPLE_W = 18
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mute_i,
  input  logic                run_done_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                flag_no
);
  logic zero_hit;
  logic muted;

  // a nonzero word releases at once, before the counter sees a strobe
  assign zero_hit = run_done_i && (sample_i == '0);
  assign muted    = mute_i || zero_hit;
  assign sample_o = (rst_ni && !muted) ? sample_i : '0;
  assign flag_no  = !rst_ni || !muted;

  AST_MUTE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_i |-> (sample_o == '0 && !flag_no)); // R7
  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mute_i && sample_i != '0) |-> (sample_o == sample_i && flag_no)); // R9
endmodule

// File: rtl/zmute_det.sv
module zmute_det #(
  parameter int unsigned SAMPLE_W  = 18,
  parameter int unsigned SHORT_RUN = 2500,
  parameter int unsigned LONG_RUN  = 12500
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_stb_i,
  input  logic                period_sel_i,
  input  logic                mute_i,
  input  logic [SAMPLE_W-1:0] sample_l_i,
  input  logic [SAMPLE_W-1:0] sample_r_i,
  output logic [SAMPLE_W-1:0] sample_l_o,
  output logic [SAMPLE_W-1:0] sample_r_o,
  output logic                mute_l_no,
  output logic                mute_r_no
);
  import zmute_pkg::*;

  logic [N_CH-1:0][SAMPLE_W-1:0] smp_in;
  logic [N_CH-1:0][SAMPLE_W-1:0] smp_out;
  logic [N_CH-1:0]               run_done;
  logic [N_CH-1:0]               flag_n;
  period_e                       period;

  assign period    = period_e'(period_sel_i);
  assign smp_in[0] = sample_l_i;
  assign smp_in[1] = sample_r_i;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    zmute_run_counter #(
      .SAMPLE_W (SAMPLE_W),
      .SHORT_RUN(SHORT_RUN),
      .LONG_RUN (LONG_RUN)
    ) u_cnt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sample_stb_i(sample_stb_i),
      .period_i    (period),
      .sample_i    (smp_in[ch]),
      .run_done_o  (run_done[ch])
    );

    zmute_gate #(
      .SAMPLE_W(SAMPLE_W)
    ) u_gate (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mute_i    (mute_i),
      .run_done_i(run_done[ch]),
      .sample_i  (smp_in[ch]),
      .sample_o  (smp_out[ch]),
      .flag_no   (flag_n[ch])
    );
  end

  assign sample_l_o = smp_out[0];
  assign sample_r_o = smp_out[1];
  assign mute_l_no  = flag_n[0];
  assign mute_r_no  = flag_n[1];

  AST_CH_ISOLATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mute_i && sample_r_i != '0) |-> mute_r_no); // R6
endmodule

// File: tb/zmute_det_test.sv
module zmute_det_test;
  localparam int unsigned SW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stb = 1'b0;
  logic          sel = 1'b0;
  logic          mute = 1'b0;
  logic [SW-1:0] sl = '0;
  logic [SW-1:0] sr = '0;
  logic [SW-1:0] ol, orr;
  logic          fl, fr;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  zmute_det uut (
    .clk_i(clk), .rst_ni(rst_n), .sample_stb_i(stb), .period_sel_i(sel),
    .mute_i(mute), .sample_l_i(sl), .sample_r_i(sr),
    .sample_l_o(ol), .sample_r_o(orr), .mute_l_no(fl), .mute_r_no(fr)
  );

  typedef struct packed {
    logic          m;
    logic [SW-1:0] l;
    logic [SW-1:0] r;
    logic [SW-1:0] el;
    logic [SW-1:0] er;
    logic          efl;
    logic          efr;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 18'h00001, 18'h3FFFF, 18'h00001, 18'h3FFFF, 1'b1, 1'b1},
    '{1'b0, 18'h20000, 18'h1FFFF, 18'h20000, 18'h1FFFF, 1'b1, 1'b1},
    '{1'b0, 18'h00000, 18'h00000, 18'h00000, 18'h00000, 1'b1, 1'b1},
    '{1'b1, 18'h12345, 18'h2ABCD, 18'h00000, 18'h00000, 1'b0, 1'b0},
    '{1'b1, 18'h00000, 18'h00000, 18'h00000, 18'h00000, 1'b0, 1'b0},
    '{1'b0, 18'h0F0F0, 18'h00000, 18'h0F0F0, 18'h00000, 1'b1, 1'b1}
  };

  task automatic chk(input logic ok, input string req, input logic [SW-1:0] act,
                     input logic [SW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // n strobed samples; ends at a negedge with strobe low
  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) stb = 1'b1;
    end
    @(negedge clk) stb = 1'b0;
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 200000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    sl = 18'h00155; sr = 18'h3FF00;
    repeat (3) @(negedge clk);
    #1;
    chk(ol == '0 && orr == '0, "R1", ol, '0);
    chk(fl && fr, "R1", {16'b0, fl, fr}, 18'h3);
    @(negedge clk) rst_n = 1'b1;

    foreach (VECS[k]) begin
      @(negedge clk);
      mute = VECS[k].m; sl = VECS[k].l; sr = VECS[k].r;
      #1;
      chk(ol == VECS[k].el, VECS[k].m ? "R7" : "R9", ol, VECS[k].el);
      chk(orr == VECS[k].er, VECS[k].m ? "R7" : "R9", orr, VECS[k].er);
      chk(fl == VECS[k].efl && fr == VECS[k].efr, VECS[k].m ? "R7" : "R9",
          {16'b0, fl, fr}, {16'b0, VECS[k].efl, VECS[k].efr});
    end

    // R2: zeros held without strobes
    @(negedge clk) mute = 1'b0; sl = '0; sr = 18'h00005; sel = 1'b0;
    repeat (3000) @(negedge clk);
    #1;
    chk(fl, "R2", {17'b0, fl}, 18'h1);

    // R3 with R6 on the other channel
    strobes(2499);
    chk(fl, "R3", {17'b0, fl}, 18'h1);
    strobes(1);
    chk(!fl, "R3", {17'b0, fl}, 18'h0);
    chk(fr && orr == 18'h00005, "R6", orr, 18'h00005);

    strobes(100);
    chk(!fl, "R8", {17'b0, fl}, 18'h0);

    // R5: release without strobe, restart on strobe
    @(negedge clk) sl = 18'h00007;
    #1;
    chk(fl && ol == 18'h00007, "R5", ol, 18'h00007);
    strobes(1);
    sl = '0;
    #1;
    chk(fl, "R5", {17'b0, fl}, 18'h1);
    strobes(1);
    chk(fl, "R5", {17'b0, fl}, 18'h1);

    // R4: long period
    sel = 1'b1;
    strobes(12498);
    chk(fl, "R4", {17'b0, fl}, 18'h1);
    strobes(1);
    chk(!fl, "R4", {17'b0, fl}, 18'h0);
    strobes(10);
    @(negedge clk) sel = 1'b0;
    #1;
    chk(!fl, "R8", {17'b0, fl}, 18'h0);

    // R7 with nonzero words
    @(negedge clk) mute = 1'b1; sl = 18'h00009; sr = 18'h00009;
    #1;
    chk(ol == '0 && orr == '0 && !fl && !fr, "R7", ol | orr, '0);
    @(negedge clk) mute = 1'b0; sl = '0;
    #1;
    chk(!fl, "R3", {17'b0, fl}, 18'h0);

    // R1: reset clears a saturated count
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk(fl && fr && orr == '0, "R1", orr, '0);
    @(negedge clk) rst_n = 1'b1;
    strobes(1);
    chk(fl, "R1", {17'b0, fl}, 18'h1);
    strobes(2498);
    chk(fl, "R1", {17'b0, fl}, 18'h1);
    strobes(1);
    chk(!fl, "R1", {17'b0, fl}, 18'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule